// File: doc/BRIEF.md
# Gated Synchronous Serial Channel

This block is one serial channel of a framed synchronous link. The link uses three lines: a frame gate, a serial clock and a data line. The block drives one set of these lines for transmit and watches a second set for receive. A processor reaches the channel through a small four-word register bus. To transmit, software writes a word, then sets the start bit together with the enable bit. The channel first gives a one-bit-period pulse on the gate. It then shifts the word out, most significant bit first, with the serial clock toggling once per half bit.

The gate has two polarities. It can idle high with a low trigger pulse, or idle low with a high trigger pulse. In both cases the data begins on the trailing edge of the pulse. A separate control bit picks which serial clock edge the receiver samples on; the transmitter changes data on the other edge. On the receive side, a trailing gate edge arms capture, and the next W sampling edges fill the receive word. Software can then poll the status word or take the interrupt. All bit timing advances only on a one-cycle enable pulse, which comes from an external clock divider in the same clock domain.

Top module: `gated_serial_channel`

## Requirements
- R1: After reset:
  - gate_o and sclk_o are high, sd_o is 0 and irq is 0.
  - The status word (address 1) reads 0.
  - The control word (address 0) reads 0: enable off, gate mode 0, rising-edge sampling, both interrupt enables off.
- R2: In gate mode 0 (control bit 1 = 0), gate_o idles high. A frame drives it low for exactly one bit_en interval. The first data bit appears on the bit_en that returns gate_o high.
- R3: In gate mode 1 (control bit 1 = 1), gate_o idles low and the pulse is high. Otherwise it behaves as in R2.
- R4: Control bit 2 selects the sampling edge.
  - With bit 2 = 0, sclk_o idles high, falls at the start of each bit and rises at mid-bit, so rising is the sampling edge.
  - With bit 2 = 1, all levels and edges are inverted.
  - sd_o changes only on the non-sampling edge.
- R5: A frame carries the W bits of the loaded word, MSB first, one bit per two bit_en pulses. Status bits behave as follows:
  - Status bit 0 (busy) is set from the start write until the last half bit ends.
  - Status bit 3 (tx done) is then set, and sd_o is 0 at idle.
- R6: The transmit state, gate_o, sclk_o and sd_o advance only on cycles with bit_en high. Without bit_en, a started frame stays armed with gate_o at its idle level.
- R7: A start (control bit 3, written together with enable bit 0 = 1) is ignored when the channel is busy or when enable is written 0. Writing the tx data register (address 2) during a frame does not change the frame in progress.
- R8: Receive capture works as follows:
  - With enable set, a trailing edge of gate_i for the current mode arms capture and restarts the bit count.
  - The next W sampling edges of sclk_i shift in sd_i, MSB first.
  - The word is then readable at address 3, and status bit 1 (rx ready) is set.
- R9: Rx ready and overrun behave as follows:
  - A read strobe at address 3 clears rx ready.
  - A completed word that arrives while rx ready is set and not being read sets status bit 2 (overrun).
  - If a completion coincides with a read, rx ready stays set and no overrun is raised.
- R10: Writing 1 to status bit 2 clears overrun, and writing 1 to status bit 3 clears tx done. A set event in the same cycle wins over the clear.
- R11: irq is (rx ready and control bit 4) or (tx done and control bit 5).
- R12: Register readback works as follows:
  - Address 0 returns enable, mode, edge and the two interrupt enables in bits 0, 1, 2, 4 and 5. The start bit reads 0.
  - Address 2 returns the last written tx word.
  - reg_rdata follows reg_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse from the external divider, one per half bit |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 tx data, 3 rx data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (only side effect: clears rx ready at address 3) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for reg_addr |
| gate_o | output | 1 | Transmit frame gate |
| sclk_o | output | 1 | Transmit serial clock |
| sd_o | output | 1 | Transmit serial data |
| gate_i | input | 1 | Receive frame gate, synchronous to clk |
| sclk_i | input | 1 | Receive serial clock, synchronous to clk |
| sd_i | input | 1 | Receive serial data |
| irq | output | 1 | Interrupt request, active high |

## Verification
Timing of results:
- The line outputs, the status bits and irq change on the clock edge that takes the bit_en, bus write or line edge causing them.
- reg_rdata follows reg_addr within the same cycle.
- A received word is ready one cycle after the sampling edge of its last bit appears on the input pins, because the pins are registered once to find edges.

The bench drives inputs and samples the receive pins half a clock before each rising edge. It advances a behavioural model on that edge and compares every output on the following falling edge, so each result is checked in the cycle it is due. Directed reads at chosen points then confirm the status, data and readback values that each requirement names.

// File: rtl/gated_serial_channel.sv
module gated_serial_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         gate_o,
  output logic         sclk_o,
  output logic         sd_o,
  input  logic         gate_i,
  input  logic         sclk_i,
  input  logic         sd_i,
  output logic         irq
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {T_IDLE, T_ARM, T_PULSE, T_BITS} tx_st_t;

  logic          en, mode, pol_fall, rx_ie, tx_ie;
  logic [W-1:0]  tx_hold, tx_sh;
  logic [CW-1:0] tx_cnt;
  logic          half, tx_done;
  tx_st_t        st;

  logic          g_q, c_q, rx_on, rx_rdy, ovr;
  logic [CW-1:0] rx_cnt;
  logic [W-1:0]  rx_sh, rx_word;

  wire wr_ctl = reg_wr && reg_addr == 2'd0;
  wire wr_st  = reg_wr && reg_addr == 2'd1;
  wire wr_tx  = reg_wr && reg_addr == 2'd2;
  wire rd_rx  = reg_rd && reg_addr == 2'd3;
  wire busy   = st != T_IDLE;
  wire start  = wr_ctl && reg_wdata[3] && reg_wdata[0] && !busy;
  wire last   = tx_cnt == CW'(W - 1);

  wire trail  = en && (mode ? (g_q && !gate_i) : (!g_q && gate_i));
  wire samp   = pol_fall ? (c_q && !sclk_i) : (!c_q && sclk_i);
  wire fin    = rx_on && !trail && samp && rx_cnt == CW'(W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; mode <= 1'b0; pol_fall <= 1'b0;
      rx_ie <= 1'b0; tx_ie <= 1'b0;
      tx_hold <= '0;
    end else begin
      if (wr_ctl) begin
        en       <= reg_wdata[0];
        mode     <= reg_wdata[1];
        pol_fall <= reg_wdata[2];
        rx_ie    <= reg_wdata[4];
        tx_ie    <= reg_wdata[5];
      end
      if (wr_tx) tx_hold <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE; tx_sh <= '0; tx_cnt <= '0; half <= 1'b0; tx_done <= 1'b0;
    end else begin
      if (wr_st && reg_wdata[3]) tx_done <= 1'b0;
      if (start) begin
        st      <= T_ARM;
        tx_sh   <= tx_hold;
        tx_done <= 1'b0;
      end else if (bit_en) begin
        case (st)
          T_ARM:   st <= T_PULSE;
          T_PULSE: begin st <= T_BITS; tx_cnt <= '0; half <= 1'b0; end
          T_BITS:
            if (!half) half <= 1'b1;
            else if (last) begin
              st <= T_IDLE; half <= 1'b0; tx_done <= 1'b1;
            end else begin
              half   <= 1'b0;
              tx_cnt <= tx_cnt + 1'b1;
              tx_sh  <= {tx_sh[W-2:0], 1'b0};
            end
          default: ;
        endcase
      end
    end
  end

  assign gate_o = (st == T_PULSE) ? mode : ~mode;
  assign sclk_o = (st == T_BITS && !half) ? pol_fall : ~pol_fall;
  assign sd_o   = (st == T_BITS) ? tx_sh[W-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q <= 1'b1; c_q <= 1'b1; rx_on <= 1'b0; rx_cnt <= '0;
      rx_sh <= '0; rx_word <= '0; rx_rdy <= 1'b0; ovr <= 1'b0;
    end else begin
      g_q <= gate_i;
      c_q <= sclk_i;
      if (rd_rx) rx_rdy <= 1'b0;
      if (wr_st && reg_wdata[2]) ovr <= 1'b0;
      if (trail) begin
        rx_on  <= 1'b1;
        rx_cnt <= '0;
      end else if (rx_on && samp) begin
        rx_sh  <= {rx_sh[W-2:0], sd_i};
        rx_cnt <= rx_cnt + 1'b1;
        if (fin) begin
          rx_on   <= 1'b0;
          rx_word <= {rx_sh[W-2:0], sd_i};
          rx_rdy  <= 1'b1;
          if (rx_rdy && !rd_rx) ovr <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(W-6){1'b0}}, tx_ie, rx_ie, 1'b0, pol_fall, mode, en};
      2'd1:    reg_rdata = {{(W-4){1'b0}}, tx_done, ovr, rx_rdy, busy};
      2'd2:    reg_rdata = tx_hold;
      default: reg_rdata = rx_word;
    endcase
  end

  assign irq = (rx_rdy && rx_ie) || (tx_done && tx_ie);
endmodule

// File: rtl/gated_serial_channel_chk.sv
module gated_serial_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       gate_o,
  input logic       sclk_o,
  input logic       sd_o,
  input logic       mode,
  input logic       busy,
  input logic       tx_done,
  input logic       rx_rdy,
  input logic       ovr,
  input logic       rd_rx,
  input logic       fin
);
  // R6
  lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_en) && !$past(reg_wr && reg_addr == 2'd0)) |->
      ($stable(gate_o) && $stable(sclk_o) && $stable(sd_o)));

  // R5
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tx_done && !sd_o));

  // R2
  pulse_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o == mode) |-> busy);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !fin) |=> !rx_rdy);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rx_rdy && !rd_rx) |=> ovr);

  // R8
  fin_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> rx_rdy);
endmodule

bind gated_serial_channel gated_serial_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .gate_o(gate_o), .sclk_o(sclk_o), .sd_o(sd_o), .mode(mode), .busy(busy),
  .tx_done(tx_done), .rx_rdy(rx_rdy), .ovr(ovr), .rd_rx(rd_rx), .fin(fin)
);

// File: tb/sim_gated_serial_channel.sv
module sim_gated_serial_channel;
  localparam int W = 16;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic gate_o, sclk_o, sd_o, irq;
  logic loop = 1'b1, drv_g = 1'b1, drv_c = 1'b1, drv_d = 1'b0;
  wire gi = loop ? gate_o : drv_g;
  wire ci = loop ? sclk_o : drv_c;
  wire di = loop ? sd_o : drv_d;

  always #(CLK_P/2) clk = ~clk;

  gated_serial_channel #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gate_o(gate_o), .sclk_o(sclk_o), .sd_o(sd_o),
    .gate_i(gi), .sclk_i(ci), .sd_i(di), .irq(irq)
  );

  int checks = 0, fails = 0, period = 3, cyc = 0;
  bit done_flag = 0;

  // reference model
  bit m_en, m_mode, m_fall, m_rie, m_tie, m_done, m_rdy, m_ovr, m_coll;
  int m_ph = -1, m_rxcnt;
  logic [W-1:0] m_hold, m_word, m_acc, m_rxw;
  bit pg = 1, pc = 1, sg, sc, sdd;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic model();
    bit trail, samp, rd_rx, start;
    if (!rst_n) begin
      {m_en, m_mode, m_fall, m_rie, m_tie, m_done, m_rdy, m_ovr, m_coll} = '0;
      m_ph = -1; m_hold = '0; m_word = '0; m_acc = '0; m_rxw = '0; m_rxcnt = 0;
      pg = 1; pc = 1;
      return;
    end
    rd_rx = reg_rd && reg_addr == 3;
    start = reg_wr && reg_addr == 0 && reg_wdata[3] && reg_wdata[0] && m_ph == -1;
    // transmit
    if (reg_wr && reg_addr == 1 && reg_wdata[3]) m_done = 0;
    if (start) begin m_ph = 0; m_word = m_hold; m_done = 0; end
    else if (bit_en && m_ph >= 0) begin
      if (m_ph == 2*W + 1) begin m_ph = -1; m_done = 1; end
      else m_ph++;
    end
    // receive
    trail = m_en && (m_mode ? (pg && !sg) : (!pg && sg));
    samp  = m_fall ? (pc && !sc) : (!pc && sc);
    if (rd_rx) m_rdy = 0;
    if (reg_wr && reg_addr == 1 && reg_wdata[2]) m_ovr = 0;
    if (trail) begin m_coll = 1; m_rxcnt = 0; end
    else if (m_coll && samp) begin
      m_acc = {m_acc[W-2:0], sdd};
      m_rxcnt++;
      if (m_rxcnt == W) begin
        m_coll = 0; m_rxw = m_acc;
        if (m_rdy && !rd_rx) m_ovr = 1;
        m_rdy = 1;
      end
    end
    pg = sg; pc = sc;
    // registers
    if (reg_wr && reg_addr == 0) begin
      m_en = reg_wdata[0]; m_mode = reg_wdata[1]; m_fall = reg_wdata[2];
      m_rie = reg_wdata[4]; m_tie = reg_wdata[5];
    end
    if (reg_wr && reg_addr == 2) m_hold = reg_wdata;
  endtask

  task automatic compare();
    bit eg, ec, ed, ei;
    logic [W-1:0] er;
    int k;
    eg = !m_mode; ec = !m_fall; ed = 0;
    if (m_ph == 1) eg = m_mode;
    if (m_ph >= 2) begin
      k = m_ph - 2;
      if (k % 2 == 0) ec = m_fall;
      ed = m_word[W-1-k/2];
    end
    ei = (m_rdy && m_rie) || (m_done && m_tie);
    case (reg_addr)
      0: er = W'({m_tie, m_rie, 1'b0, m_fall, m_mode, m_en});
      1: er = W'({m_done, m_ovr, m_rdy, m_ph != -1});
      2: er = m_hold;
      default: er = m_rxw;
    endcase
    chk(gate_o === eg, m_mode ? "R3 gate" : "R2 gate", W'(gate_o), W'(eg));
    chk(sclk_o === ec, "R4 sclk", W'(sclk_o), W'(ec));
    chk(sd_o === ed, "R5 data", W'(sd_o), W'(ed));
    chk(irq === ei, "R11 irq", W'(irq), W'(ei));
    chk(reg_rdata === er, "R12 rdata", reg_rdata, er);
  endtask

  task automatic tick();
    bit_en = (period > 0) && (cyc % (period > 0 ? period : 1) == 0);
    cyc++;
    #1; sg = gi; sc = ci; sdd = di;
    @(posedge clk); model();
    @(negedge clk); compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [W-1:0] e, input string req);
    reg_addr = a; #1; chk(reg_rdata === e, req, reg_rdata, e);
  endtask

  task automatic rd_pop();
    reg_addr = 3; reg_rd = 1; tick(); reg_rd = 0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    @(negedge clk);
    run(3);
    rst_n = 1; tick();
    // R1 reset state
    chk(gate_o === 1'b1, "R1 gate", W'(gate_o), 1);
    chk(sclk_o === 1'b1, "R1 sclk", W'(sclk_o), 1);
    chk(irq === 1'b0, "R1 irq", W'(irq), 0);
    rd_chk(1, 0, "R1 status");
    rd_chk(0, 0, "R1 control");

    // R2 R5 R7 R8: mode 0, rising sampling, loopback, bit_en every 3 cycles
    period = 3;
    wr(2, 16'hA5C3);
    wr(0, 16'h0019);
    run(10);
    rd_chk(1, 16'h0001, "R5 busy");
    wr(2, 16'h1234);
    wr(0, 16'h0019);
    run(120);
    rd_chk(3, 16'hA5C3, "R7 frame kept / R8 word");
    rd_chk(1, 16'h000A, "R5 done and R8 ready");
    chk(irq === 1'b1, "R11 rx irq", W'(irq), 1);
    rd_pop();
    rd_chk(1, 16'h0008, "R9 read clears ready");
    wr(1, 16'h0008);
    rd_chk(1, 16'h0000, "R10 clear done");

    // R3 R4: mode 1, falling sampling, bit_en every cycle
    period = 1;
    wr(2, 16'h8001);
    wr(0, 16'h002F);
    run(50);
    chk(irq === 1'b1, "R11 tx irq", W'(irq), 1);
    rd_chk(3, 16'h8001, "R3 mode1 word");
    wr(2, 16'h7FFE);
    wr(0, 16'h002F);
    run(50);
    rd_chk(1, 16'h000E, "R9 overrun");
    rd_chk(3, 16'h7FFE, "R8 second word");
    wr(1, 16'h000C);
    rd_chk(1, 16'h0002, "R10 clear overrun");
    rd_pop();

    // R7: start without enable
    wr(0, 16'h0008);
    run(10);
    rd_chk(1, 16'h0000, "R7 start ignored");

    // R6: no bit_en, frame stays armed
    period = 0;
    wr(0, 16'h0009);
    run(20);
    rd_chk(1, 16'h0001, "R6 armed");
    chk(gate_o === 1'b1, "R6 gate idle", W'(gate_o), 1);
    period = 2;
    run(80);
    rd_chk(3, 16'h7FFE, "R8 after stall");

    // R12 readback
    wr(0, 16'h0035);
    rd_chk(0, 16'h0035, "R12 control");
    rd_chk(2, 16'h7FFE, "R12 tx data");
    run(2);
    finish_up();
  end
endmodule